// File: doc/BRIEF.md
# Serial Transfer Conflict Error Monitor

This block supervises a synchronous serial transfer engine that works either as bus master or as a selected slave. It watches the external select line, the current role, the frame-start and frame-end strobes from the shifter, and the host's servicing of the receive and transmit data buffers. When it sees a select conflict, an aborted slave transfer or a missed buffer service, it raises a single sticky error flag.

Once the flag rises, the block stops the shifter and refuses new frames. This holds until a sequencer reset is issued, and it still holds after software has cleared the flag. Software clears the flag through a small register-style protocol: first a read that returns 1, then a write of 0. The shifter and the clock generator are outside this block and are seen only through the strobes.

Top module: `sxm_err_monitor`

## Requirements
- R1: After reset, err_o, busy_o and shift_en_o are all 0.
- R2: With master_i=1, a low level on sel_i sets err_o. The level passes a two-flop synchronizer, so err_o goes high on the third rising clock edge after sel_i falls. While sel_i stays high in master mode, no error is raised.
- R3: With master_i=0, a rise of the synchronized sel_i while busy_o=1 sets err_o on the third edge after sel_i rises. A rise while no transfer is in progress sets nothing.
- R4: In slave mode with rx_op_i=1, each accepted frame end leaves receive data pending. Service is complete only after both a rx_read_i pulse and a rx_full_clr_i pulse. If service is not complete when the next frame starts, err_o is set at the end of that next frame and not before.
- R5: In slave mode with tx_op_i=1, the same rule applies to the transmit side. There, service needs both a tx_write_i pulse and a tx_empty_clr_i pulse.
- R6: When no error is blocking, a frame_start_i pulse makes busy_o high from the next cycle until the edge that samples frame_end_i. shift_en_o equals busy_o while nothing blocks.
- R7: Once err_o has been set, shift_en_o is 0 and frame_start_i is ignored. This lasts until seq_reset_i is pulsed, even if err_o has already been cleared.
- R8: err_o clears only on a write (err_wr_i with err_wdata_i=0) that follows a read (err_rd_i) which saw err_o=1. A write of 0 with no such prior read leaves err_o at 1.
- R9: A write with err_wdata_i=1 cancels a pending read, so a following write of 0 does not clear err_o.
- R10: If a setting condition and a valid clear fall in the same cycle, err_o stays 1.
- R11: seq_reset_i returns the frame sequencer to idle and drops any partial frame and any pending buffer state. It leaves err_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master role, 0 = slave role |
| sel_i | input | 1 | External select line, asynchronous, low = selected |
| frame_start_i | input | 1 | Frame-start strobe from the shifter |
| frame_end_i | input | 1 | Frame-end strobe from the shifter |
| rx_op_i | input | 1 | Slave receive operation enabled |
| tx_op_i | input | 1 | Slave transmit operation enabled |
| rx_read_i | input | 1 | Host read the receive data |
| rx_full_clr_i | input | 1 | Host cleared the receive-full flag |
| tx_write_i | input | 1 | Host wrote transmit data |
| tx_empty_clr_i | input | 1 | Host cleared the transmit-empty flag |
| seq_reset_i | input | 1 | Sequencer reset request |
| err_rd_i | input | 1 | Read strobe of the error flag |
| err_wr_i | input | 1 | Write strobe of the error flag |
| err_wdata_i | input | 1 | Write data for the error flag |
| err_o | output | 1 | Sticky error flag, also the read data |
| busy_o | output | 1 | Transfer in progress |
| shift_en_o | output | 1 | Shifter may run |

## Verification
The select line is driven three ways: low in master mode, which must raise the flag on an exact edge; rising in slave mode mid-frame; and rising in slave mode while idle. Together these separate the level check from the edge check and show that the edge check is qualified by the busy state. Buffer handling is tried in four forms: no service, complete service, read without flag-clear, and flag-clear without write. This shows that both host actions are needed and that the flag appears only at the frame end. The clear protocol is driven with a bare write of 0, an armed write of 0, a write of 1 between the read and the write, and a clear that collides with a live conflict. These tell the arming rule apart from the set-over-clear priority.

// File: rtl/sxm_pkg.sv
package sxm_pkg;
  typedef enum logic [1:0] {
    FR_IDLE   = 2'd0,
    FR_ACTIVE = 2'd1,
    FR_END    = 2'd2
  } frame_state_e;

  localparam int unsigned NUM_BUF = 2;  // 0: receive, 1: transmit
endpackage

// File: rtl/sxm_sel_sync.sv
module sxm_sel_sync #(
  parameter int unsigned Stages = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic sel_s_o,
  output logic sel_rise_o
);
  localparam int unsigned Msb = Stages - 1;

  logic [Stages-1:0] sync_q;
  logic              last_q;

  // reset to deasserted (high) level so no false conflict appears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[Msb-1:0], sel_i};
      last_q <= sync_q[Msb];
    end
  end

  assign sel_s_o    = sync_q[Msb];
  assign sel_rise_o = sync_q[Msb] & ~last_q;
endmodule

// File: rtl/sxm_frame_fsm.sv
module sxm_frame_fsm
  import sxm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic frame_end_i,
  input  logic blocked_i,
  input  logic seq_reset_i,
  output logic busy_o,
  output logic start_evt_o,
  output logic end_evt_o
);
  frame_state_e state_q, state_d;

  assign start_evt_o = (state_q != FR_ACTIVE) & frame_start_i & ~blocked_i & ~seq_reset_i;
  assign end_evt_o   = (state_q == FR_ACTIVE) & frame_end_i & ~blocked_i & ~seq_reset_i;
  assign busy_o      = (state_q == FR_ACTIVE);

  always_comb begin
    state_d = state_q;
    if (seq_reset_i) begin
      state_d = FR_IDLE;
    end else begin
      case (state_q)
        FR_IDLE:   if (start_evt_o) state_d = FR_ACTIVE;
        FR_ACTIVE: begin
          if (blocked_i)      state_d = FR_IDLE;
          else if (end_evt_o) state_d = FR_END;
        end
        FR_END:    state_d = start_evt_o ? FR_ACTIVE : FR_IDLE;
        default:   state_d = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FR_IDLE;
    else         state_q <= state_d;
  end

  // R11: sequencer reset always lands in idle
  a_r11_reset_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_reset_i |=> !busy_o);
endmodule

// File: rtl/sxm_buf_track.sv
module sxm_buf_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_evt_i,
  input  logic end_evt_i,
  input  logic host_data_i,
  input  logic host_flag_i,
  input  logic flush_i,
  output logic miss_o
);
  logic pending_q, data_seen_q, flag_seen_q, miss_q;
  logic svc_done;

  assign svc_done = pending_q & (data_seen_q | host_data_i) & (flag_seen_q | host_flag_i);
  assign miss_o   = miss_q & end_evt_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q   <= 1'b0;
      data_seen_q <= 1'b0;
      flag_seen_q <= 1'b0;
      miss_q      <= 1'b0;
    end else if (flush_i) begin
      pending_q   <= 1'b0;
      data_seen_q <= 1'b0;
      flag_seen_q <= 1'b0;
      miss_q      <= 1'b0;
    end else if (end_evt_i && en_i) begin
      pending_q   <= 1'b1;
      data_seen_q <= 1'b0;
      flag_seen_q <= 1'b0;
      miss_q      <= 1'b0;
    end else begin
      if (svc_done) begin
        pending_q   <= 1'b0;
        data_seen_q <= 1'b0;
        flag_seen_q <= 1'b0;
      end else if (pending_q) begin
        data_seen_q <= data_seen_q | host_data_i;
        flag_seen_q <= flag_seen_q | host_flag_i;
      end
      if (start_evt_i && en_i) miss_q <= pending_q & ~svc_done;
    end
  end
endmodule

// File: rtl/sxm_err_flag.sv
module sxm_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic seq_reset_i,
  output logic err_o,
  output logic blocked_o
);
  logic err_q, armed_q, blocked_q;
  logic clr_ok;

  assign clr_ok = wr_i & ~wdata_i & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q     <= 1'b0;
      armed_q   <= 1'b0;
      blocked_q <= 1'b0;
    end else begin
      // setting wins over clearing
      if (set_i)       err_q <= 1'b1;
      else if (clr_ok) err_q <= 1'b0;

      if (seq_reset_i || (wr_i && wdata_i)) armed_q <= 1'b0;
      else if (rd_i && err_q)               armed_q <= 1'b1;
      else if (clr_ok && !set_i)            armed_q <= 1'b0;

      if (set_i)            blocked_q <= 1'b1;
      else if (seq_reset_i) blocked_q <= 1'b0;
    end
  end

  assign err_o     = err_q;
  assign blocked_o = blocked_q;

  // R8: clearing needs an armed write of 0
  a_r8_clear_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_q) |-> $past(armed_q && wr_i && !wdata_i));
  // R8: flag is sticky without a write
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !wr_i) |=> err_q);
endmodule

// File: rtl/sxm_err_monitor.sv
module sxm_err_monitor
  import sxm_pkg::*;
#(
  parameter int unsigned SyncStages = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic sel_i,
  input  logic frame_start_i,
  input  logic frame_end_i,
  input  logic rx_op_i,
  input  logic tx_op_i,
  input  logic rx_read_i,
  input  logic rx_full_clr_i,
  input  logic tx_write_i,
  input  logic tx_empty_clr_i,
  input  logic seq_reset_i,
  input  logic err_rd_i,
  input  logic err_wr_i,
  input  logic err_wdata_i,
  output logic err_o,
  output logic busy_o,
  output logic shift_en_o
);
  logic sel_s, sel_rise;
  logic busy, start_evt, end_evt;
  logic blocked, err_w;
  logic conflict_set, abort_set, miss_set;
  logic [NUM_BUF-1:0] buf_en, buf_data, buf_flag, buf_miss;

  sxm_sel_sync #(.Stages(SyncStages)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .sel_s_o   (sel_s),
    .sel_rise_o(sel_rise)
  );

  sxm_frame_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .frame_end_i  (frame_end_i),
    .blocked_i    (blocked),
    .seq_reset_i  (seq_reset_i),
    .busy_o       (busy),
    .start_evt_o  (start_evt),
    .end_evt_o    (end_evt)
  );

  assign buf_en   = {tx_op_i & ~master_i, rx_op_i & ~master_i};
  assign buf_data = {tx_write_i, rx_read_i};
  assign buf_flag = {tx_empty_clr_i, rx_full_clr_i};

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    sxm_buf_track u_trk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (buf_en[b]),
      .start_evt_i(start_evt),
      .end_evt_i  (end_evt),
      .host_data_i(buf_data[b]),
      .host_flag_i(buf_flag[b]),
      .flush_i    (seq_reset_i),
      .miss_o     (buf_miss[b])
    );
  end

  assign conflict_set = master_i & ~sel_s;
  assign abort_set    = ~master_i & sel_rise & busy;
  assign miss_set     = |buf_miss;

  sxm_err_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (conflict_set | abort_set | miss_set),
    .rd_i       (err_rd_i),
    .wr_i       (err_wr_i),
    .wdata_i    (err_wdata_i),
    .seq_reset_i(seq_reset_i),
    .err_o      (err_w),
    .blocked_o  (blocked)
  );

  assign err_o      = err_w;
  assign busy_o     = busy;
  assign shift_en_o = busy & ~blocked;

  // R2: master conflict raises the flag
  a_r2_master_conflict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !sel_s) |=> err_o);
  // R7: shifting halts as soon as an error appears
  a_r7_halt_on_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !shift_en_o);
endmodule

// File: tb/tb_sxm_err_monitor.sv
module tb_sxm_err_monitor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master_i = 1'b1, sel_i = 1'b1;
  logic frame_start_i = 1'b0, frame_end_i = 1'b0;
  logic rx_op_i = 1'b0, tx_op_i = 1'b0;
  logic rx_read_i = 1'b0, rx_full_clr_i = 1'b0, tx_write_i = 1'b0, tx_empty_clr_i = 1'b0;
  logic seq_reset_i = 1'b0, err_rd_i = 1'b0, err_wr_i = 1'b0, err_wdata_i = 1'b0;
  logic err_o, busy_o, shift_en_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sxm_err_monitor dut (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master_i), .sel_i(sel_i),
    .frame_start_i(frame_start_i), .frame_end_i(frame_end_i),
    .rx_op_i(rx_op_i), .tx_op_i(tx_op_i),
    .rx_read_i(rx_read_i), .rx_full_clr_i(rx_full_clr_i),
    .tx_write_i(tx_write_i), .tx_empty_clr_i(tx_empty_clr_i),
    .seq_reset_i(seq_reset_i), .err_rd_i(err_rd_i), .err_wr_i(err_wr_i),
    .err_wdata_i(err_wdata_i),
    .err_o(err_o), .busy_o(busy_o), .shift_en_o(shift_en_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic p_start(); frame_start_i = 1; step(1); frame_start_i = 0; endtask
  task automatic p_end();   frame_end_i = 1;   step(1); frame_end_i = 0;   endtask
  task automatic p_rd();    err_rd_i = 1;      step(1); err_rd_i = 0;      endtask
  task automatic p_seq();   seq_reset_i = 1;   step(1); seq_reset_i = 0;   endtask
  task automatic p_wr(input logic d);
    err_wr_i = 1; err_wdata_i = d; step(1); err_wr_i = 0; err_wdata_i = 0;
  endtask
  task automatic clear_all(); p_rd(); p_wr(1'b0); p_seq(); endtask

  task automatic t_reset();
    chk("R1 err", err_o, 1'b0);
    chk("R1 busy", busy_o, 1'b0);
    chk("R1 shift", shift_en_o, 1'b0);
  endtask

  task automatic t_frame_basic();
    master_i = 1; sel_i = 1; step(3);
    p_start();
    chk("R6 busy after start", busy_o, 1'b1);
    chk("R6 shift after start", shift_en_o, 1'b1);
    step(2);
    chk("R2 no error with sel high", err_o, 1'b0);
    p_end();
    chk("R6 busy after end", busy_o, 1'b0);
  endtask

  task automatic t_master_conflict();
    sel_i = 0; step(2);
    chk("R2 latency two edges", err_o, 1'b0);
    step(1);
    chk("R2 conflict set", err_o, 1'b1);
    sel_i = 1; step(3);
    p_start();
    chk("R7 start ignored", busy_o, 1'b0);
    chk("R7 no shift", shift_en_o, 1'b0);
  endtask

  task automatic t_clear();
    p_wr(1'b0);
    chk("R8 bare write 0", err_o, 1'b1);
    p_rd(); p_wr(1'b1); p_wr(1'b0);
    chk("R9 write 1 disarms", err_o, 1'b1);
    p_rd(); p_wr(1'b0);
    chk("R8 armed clear", err_o, 1'b0);
    p_start();
    chk("R7 still blocked after clear", busy_o, 1'b0);
    p_seq(); p_start();
    chk("R7 resumes after seq reset", busy_o, 1'b1);
    p_end();
  endtask

  task automatic t_priority();
    sel_i = 0; step(3);
    chk("R2 conflict again", err_o, 1'b1);
    p_rd(); p_wr(1'b0);
    chk("R10 set beats clear", err_o, 1'b1);
    sel_i = 1; step(3);
    p_rd(); p_wr(1'b0);
    chk("R10 clear once released", err_o, 1'b0);
    p_seq();
  endtask

  task automatic t_slave_abort();
    master_i = 0; step(1);
    sel_i = 0; step(3);
    sel_i = 1; step(3);
    chk("R3 idle rise ignored", err_o, 1'b0);
    sel_i = 0; step(3);
    p_start();
    chk("R6 slave busy", busy_o, 1'b1);
    sel_i = 1; step(2);
    chk("R3 latency", err_o, 1'b0);
    step(1);
    chk("R3 abort set", err_o, 1'b1);
    chk("R7 shift stopped", shift_en_o, 1'b0);
    p_seq();
    chk("R11 seq reset keeps flag", err_o, 1'b1);
    p_rd(); p_wr(1'b0);
    chk("R8 clear after abort", err_o, 1'b0);
    sel_i = 0; step(3);
  endtask

  task automatic t_rx_miss();
    rx_op_i = 1;
    p_start(); p_end();
    chk("R4 first frame clean", err_o, 1'b0);
    p_start(); step(2);
    chk("R4 not before frame end", err_o, 1'b0);
    p_end();
    chk("R4 unserviced miss", err_o, 1'b1);
    clear_all();
    p_start(); p_end();
    rx_read_i = 1; step(1); rx_read_i = 0;
    rx_full_clr_i = 1; step(1); rx_full_clr_i = 0;
    p_start(); p_end();
    chk("R4 full service ok", err_o, 1'b0);
    rx_read_i = 1; step(1); rx_read_i = 0;
    p_start(); p_end();
    chk("R4 read only misses", err_o, 1'b1);
    clear_all();
    rx_op_i = 0;
  endtask

  task automatic t_tx_miss();
    tx_op_i = 1;
    p_start(); p_end();
    tx_write_i = 1; tx_empty_clr_i = 1; step(1);
    tx_write_i = 0; tx_empty_clr_i = 0;
    p_start(); p_end();
    chk("R5 full service ok", err_o, 1'b0);
    tx_empty_clr_i = 1; step(1); tx_empty_clr_i = 0;
    p_start(); step(1);
    chk("R5 not before frame end", err_o, 1'b0);
    p_end();
    chk("R5 clear only misses", err_o, 1'b1);
    clear_all();
    tx_op_i = 0;
  endtask

  task automatic t_seq_flush();
    rx_op_i = 1;
    p_start(); p_end();
    p_start();
    chk("R6 busy before flush", busy_o, 1'b1);
    p_seq();
    chk("R11 partial frame dropped", busy_o, 1'b0);
    p_end();
    chk("R11 stray end ignored", busy_o, 1'b0);
    p_start(); p_end();
    chk("R11 pending dropped", err_o, 1'b0);
    rx_op_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(2);
    t_reset();
    rst_ni = 1;
    step(2);
    t_reset();
    t_frame_basic();
    t_master_conflict();
    t_clear();
    t_priority();
    t_slave_abort();
    t_rx_miss();
    t_tx_miss();
    t_seq_flush();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule